// File: doc/BRIEF.md
# Multi-Setup ADC Conversion Sequencer

This block is the digital control core of a converter that can measure several input setups in turn. A host writes and reads a 24-bit configuration word. Fields in that word pick the amplifier chop rate and the number of setups in a sequence. Other fields make up a sequencing policy: convert one setup or a list of setups, run the work once or repeat it, and, when repeating, either wait or not wait for the host to collect each result before the next conversion starts. The word also holds a reset-cycle control bit and three sticky status flags.

On a conversion or calibration command the sequencer drives a setup index and a one-cycle start strobe toward the converter. It then waits for the converter's done pulse. A normal conversion's result and its setup index are captured, and data-ready is raised. Data-ready drops when the host strobes a read. The block also drives a base-clock divide ratio for the chosen chop rate, and the count of setup registers that a register access should cover.

Top module: `adc_seq_top`

## Requirements
- R1: Configuration bits 23:22, 19 and 3:0 always read as 0, and host writes to status bits 6:4 are ignored. After a write of all ones and no reset-cycle exit, the read value is 0x37FF80.
- R2: After reset, every configuration bit reads 0, the sequencer is idle (busy 0, convStart 0) and dataReady is 0.
- R3: chopDiv follows bits 21:20: 00 gives 128, 01 gives 8, 10 gives 2 and 11 gives 32 (256, 4096, 16384 and 1024 Hz from a 32.768 kHz base).
- R4: accessCnt equals the depth field (bits 15:12) plus one, from 1 to 16.
- R5: When bit 18 is 0, or the command's multi flag is 0, a conversion command starts exactly one conversion, on setup 0.
- R6: When bit 18 is 1 and the command's multi flag is 1, the sequencer starts conversions on setups 0, 1, … up to the depth value, in that order and one at a time.
- R7: With bit 17 (loop) at 0, the sequencer goes idle after the done pulse of the last setup. With loop at 1, it restarts at setup 0 and continues until a reset cycle stops it.
- R8: With loop at 1 and bit 16 (read-convert) at 1, no new start is issued after a result until the host read strobe is seen. The start follows on the next cycle. With loop at 0, bit 16 has no effect.
- R9: A done pulse for a conversion in flight captures convData and the setup index and sets dataReady. dataReady is 0 on the cycle after a host read strobe.
- R10: A calibration command drives convCal high, uses setup 0 only and ignores bits 18 and 16. It still honours loop, and it does not touch dataReady.
- R11: Writing 1 to bit 7 forces the sequencer idle and blocks commands while the bit stays 1. Writing it back to 0 sets bit 6. Bit 6 clears after a cycle with cfgRdEn high.
- R12: Bit 4 is set by a captured done with convOvr high, and bit 5 by one with convOsc high. Both stay set through host writes and clear when a reset cycle begins.
- R13: A done pulse while no conversion is in flight changes neither dataReady nor the status flags.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cfgWrEn | input | 1 | Configuration write strobe |
| cfgWrData | input | 24 | Configuration write value |
| cfgRdEn | input | 1 | Configuration read strobe (clears bit 6) |
| cfgRdData | output | 24 | Current configuration and status word |
| cmdValid | input | 1 | Command strobe |
| cmdMulti | input | 1 | Command requests a setup list |
| cmdCal | input | 1 | Command is a calibration |
| convStart | output | 1 | One-cycle start toward converter |
| convSetup | output | IDX_W | Setup index for the conversion |
| convCal | output | 1 | Current operation is a calibration |
| convDone | input | 1 | Converter finished pulse |
| convData | input | DATA_W | Converter result |
| convOvr | input | 1 | Converter saw overrange |
| convOsc | input | 1 | Converter saw oscillation |
| dataReady | output | 1 | Result waiting for host |
| dataOut | output | DATA_W | Captured result |
| dataSetup | output | IDX_W | Setup of captured result |
| hostRead | input | 1 | Host takes the result |
| busy | output | 1 | Sequencer not idle |
| chopDiv | output | 8 | Base-clock divide ratio for chop |
| accessCnt | output | 5 | Setup registers per register access |

## Verification
The bench sweeps the multi-setup bit, the command's multi flag and several depths, including the full depth of 15. A design that ignored either multi condition, or that was off by one at the end of the list, would issue a missing or extra start, or one on the wrong setup. In looped read-convert mode it watches several idle cycles after each result, which catches a sequencer that runs ahead of the host. It also checks that the same bit changes nothing once loop is off. Calibration under a full multi, loop and read-convert setting must stay on setup 0 and leave data-ready low. Stray done pulses, writes to the status flags and the exit from a reset cycle are probed for the flags leaking, sticking or clearing at the wrong time.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;
  localparam int CFG_W      = 24;
  localparam int BIT_CFS_HI = 21;
  localparam int BIT_CFS_LO = 20;
  localparam int BIT_MC     = 18;
  localparam int BIT_LP     = 17;
  localparam int BIT_RC     = 16;
  localparam int BIT_DP_HI  = 15;
  localparam int BIT_DP_LO  = 12;
  localparam int DP_W       = BIT_DP_HI - BIT_DP_LO + 1;
  localparam int BIT_RS     = 7;
  localparam int BIT_RV     = 6;
  localparam int BIT_OD     = 5;
  localparam int BIT_OF     = 4;
  localparam int CHOP_W     = 8;
  localparam int ACC_W      = DP_W + 1;
  localparam logic [CFG_W-1:0] WR_MASK = 24'h37FF80;

  typedef enum logic [1:0] {sIdle, sStart, sWaitDone, sWaitRead} seqState_t;

  typedef struct packed {
    logic capture;    // done accepted for a conversion in flight
    logic storeData;  // capture of a normal (non-calibration) result
  } seqStrobe_t;

  function automatic logic [CHOP_W-1:0] chopRatio(input logic [1:0] sel);
    case (sel)
      2'b00:   chopRatio = CHOP_W'(128);
      2'b01:   chopRatio = CHOP_W'(8);
      2'b10:   chopRatio = CHOP_W'(2);
      default: chopRatio = CHOP_W'(32);
    endcase
  endfunction
endpackage

// File: rtl/adc_seq_regs.sv
module adc_seq_regs
  import adc_seq_pkg::*;
#(
  parameter int DATA_W = 24,
  parameter int IDX_W  = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cfgWrEn,
  input  logic [CFG_W-1:0]  cfgWrData,
  input  logic              cfgRdEn,
  output logic [CFG_W-1:0]  cfgRdData,
  input  seqStrobe_t        strobe,
  input  logic [DATA_W-1:0] convData,
  input  logic [IDX_W-1:0]  convSetup,
  input  logic              convOvr,
  input  logic              convOsc,
  input  logic              hostRead,
  output logic              dataReady,
  output logic [DATA_W-1:0] dataOut,
  output logic [IDX_W-1:0]  dataSetup,
  output logic              mcEn,
  output logic              lpEn,
  output logic              rcEn,
  output logic [DP_W-1:0]   depth,
  output logic              sysRst,
  output logic [CHOP_W-1:0] chopDiv,
  output logic [ACC_W-1:0]  accessCnt
);
  logic [CFG_W-1:0] cfgHeld;
  logic rvFlag, flagOsc, flagOvr;
  logic rstCycleStart, rstCycleEnd;

  assign rstCycleStart = cfgWrEn && cfgWrData[BIT_RS] && !cfgHeld[BIT_RS];
  assign rstCycleEnd   = cfgWrEn && !cfgWrData[BIT_RS] && cfgHeld[BIT_RS];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cfgHeld <= '0;
      rvFlag  <= 1'b0;
      flagOsc <= 1'b0;
      flagOvr <= 1'b0;
    end else begin
      if (cfgWrEn) cfgHeld <= cfgWrData & WR_MASK;
      if (rstCycleEnd)  rvFlag <= 1'b1;
      else if (cfgRdEn) rvFlag <= 1'b0;
      if (rstCycleStart) begin
        flagOsc <= 1'b0;
        flagOvr <= 1'b0;
      end else if (strobe.capture) begin
        flagOsc <= flagOsc | convOsc;
        flagOvr <= flagOvr | convOvr;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      dataReady <= 1'b0;
      dataOut   <= '0;
      dataSetup <= '0;
    end else if (strobe.storeData) begin
      dataReady <= 1'b1;
      dataOut   <= convData;
      dataSetup <= convSetup;
    end else if (hostRead) begin
      dataReady <= 1'b0;
    end
  end

  always_comb begin
    cfgRdData         = cfgHeld;
    cfgRdData[BIT_RV] = rvFlag;
    cfgRdData[BIT_OD] = flagOsc;
    cfgRdData[BIT_OF] = flagOvr;
  end

  assign mcEn      = cfgHeld[BIT_MC];
  assign lpEn      = cfgHeld[BIT_LP];
  assign rcEn      = cfgHeld[BIT_RC];
  assign depth     = cfgHeld[BIT_DP_HI:BIT_DP_LO];
  assign sysRst    = cfgHeld[BIT_RS];
  assign chopDiv   = chopRatio(cfgHeld[BIT_CFS_HI:BIT_CFS_LO]);
  assign accessCnt = {1'b0, depth} + ACC_W'(1);

  // R12: a set overrange flag survives everything except a new reset cycle
  a_r12_ovr_sticky: assert property (@(posedge clk) disable iff (!rstN)
    flagOvr && !rstCycleStart |=> flagOvr);
  // R11: a read clears the valid-reset flag unless a reset cycle ends at once
  a_r11_rv_read_clear: assert property (@(posedge clk) disable iff (!rstN)
    cfgRdEn && !rstCycleEnd |=> !cfgRdData[BIT_RV]);
  // R9: host read drops data-ready when no new result lands
  a_r9_ready_drop: assert property (@(posedge clk) disable iff (!rstN)
    hostRead && !strobe.storeData |=> !dataReady);
endmodule

// File: rtl/adc_seq_ctrl.sv
module adc_seq_ctrl
  import adc_seq_pkg::*;
#(
  parameter int MAX_SETUPS = 16,
  parameter int IDX_W      = 4
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             cmdValid,
  input  logic             cmdMulti,
  input  logic             cmdCal,
  input  logic             mcEn,
  input  logic             lpEn,
  input  logic             rcEn,
  input  logic [DP_W-1:0]  depth,
  input  logic             sysRst,
  input  logic             convDone,
  input  logic             hostRead,
  output logic             convStart,
  output logic [IDX_W-1:0] convSetup,
  output logic             convCal,
  output logic             busy,
  output seqStrobe_t       strobe
);
  localparam logic [DP_W-1:0] MAX_IDX = DP_W'(MAX_SETUPS - 1);

  seqState_t        curState;
  logic [IDX_W-1:0] seqIdx, lastIdxQ, clipIdx;
  logic [DP_W-1:0]  clipDepth;
  logic             loopQ, rcQ, calQ, multiNow, endOfList;

  assign clipDepth = (depth > MAX_IDX) ? MAX_IDX : depth;
  assign clipIdx   = clipDepth[IDX_W-1:0];
  assign multiNow  = cmdMulti && mcEn && !cmdCal;
  assign endOfList = (seqIdx == lastIdxQ);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      curState <= sIdle;
      seqIdx   <= '0;
      lastIdxQ <= '0;
      loopQ    <= 1'b0;
      rcQ      <= 1'b0;
      calQ     <= 1'b0;
    end else if (sysRst) begin
      curState <= sIdle;
    end else begin
      case (curState)
        sIdle: if (cmdValid) begin
          calQ     <= cmdCal;
          loopQ    <= lpEn;
          rcQ      <= rcEn && lpEn && !cmdCal;
          lastIdxQ <= multiNow ? clipIdx : '0;
          seqIdx   <= '0;
          curState <= sStart;
        end
        sStart: curState <= sWaitDone;
        sWaitDone: if (convDone) begin
          if (endOfList && !loopQ) begin
            curState <= sIdle;
          end else begin
            seqIdx   <= endOfList ? '0 : seqIdx + IDX_W'(1);
            curState <= rcQ ? sWaitRead : sStart;
          end
        end
        sWaitRead: if (hostRead) curState <= sStart;
        default: curState <= sIdle;
      endcase
    end
  end

  assign convStart         = (curState == sStart);
  assign convSetup         = seqIdx;
  assign convCal           = calQ && (curState != sIdle);
  assign busy              = (curState != sIdle);
  assign strobe.capture    = (curState == sWaitDone) && convDone && !sysRst;
  assign strobe.storeData  = strobe.capture && !calQ;

  // R6: every start addresses a setup inside the active list
  a_r6_start_in_range: assert property (@(posedge clk) disable iff (!rstN)
    convStart |-> seqIdx <= lastIdxQ);
  // R8: under read-convert a start follows a host read or a fresh command
  a_r8_wait_for_read: assert property (@(posedge clk) disable iff (!rstN)
    convStart && rcQ |-> $past(hostRead) || $past(curState) == sIdle);
  // R10: calibrations stay on setup 0
  a_r10_cal_single: assert property (@(posedge clk) disable iff (!rstN)
    convStart && convCal |-> convSetup == '0);
  // R11: a reset cycle forces idle
  a_r11_hold_idle: assert property (@(posedge clk) disable iff (!rstN)
    sysRst |=> !busy);
endmodule

// File: rtl/adc_seq_top.sv
module adc_seq_top
  import adc_seq_pkg::*;
#(
  parameter int DATA_W     = 24,
  parameter int MAX_SETUPS = 16,
  parameter int IDX_W      = $clog2(MAX_SETUPS)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cfgWrEn,
  input  logic [23:0]       cfgWrData,
  input  logic              cfgRdEn,
  output logic [23:0]       cfgRdData,
  input  logic              cmdValid,
  input  logic              cmdMulti,
  input  logic              cmdCal,
  output logic              convStart,
  output logic [IDX_W-1:0]  convSetup,
  output logic              convCal,
  input  logic              convDone,
  input  logic [DATA_W-1:0] convData,
  input  logic              convOvr,
  input  logic              convOsc,
  output logic              dataReady,
  output logic [DATA_W-1:0] dataOut,
  output logic [IDX_W-1:0]  dataSetup,
  input  logic              hostRead,
  output logic              busy,
  output logic [7:0]        chopDiv,
  output logic [4:0]        accessCnt
);
  seqStrobe_t      strobe;
  logic            mcEn, lpEn, rcEn, sysRst;
  logic [DP_W-1:0] depth;

  adc_seq_regs #(.DATA_W(DATA_W), .IDX_W(IDX_W)) uRegs (
    .clk(clk), .rstN(rstN), .cfgWrEn(cfgWrEn), .cfgWrData(cfgWrData),
    .cfgRdEn(cfgRdEn), .cfgRdData(cfgRdData), .strobe(strobe),
    .convData(convData), .convSetup(convSetup), .convOvr(convOvr),
    .convOsc(convOsc), .hostRead(hostRead), .dataReady(dataReady),
    .dataOut(dataOut), .dataSetup(dataSetup), .mcEn(mcEn), .lpEn(lpEn),
    .rcEn(rcEn), .depth(depth), .sysRst(sysRst), .chopDiv(chopDiv),
    .accessCnt(accessCnt)
  );

  adc_seq_ctrl #(.MAX_SETUPS(MAX_SETUPS), .IDX_W(IDX_W)) uCtrl (
    .clk(clk), .rstN(rstN), .cmdValid(cmdValid), .cmdMulti(cmdMulti),
    .cmdCal(cmdCal), .mcEn(mcEn), .lpEn(lpEn), .rcEn(rcEn), .depth(depth),
    .sysRst(sysRst), .convDone(convDone), .hostRead(hostRead),
    .convStart(convStart), .convSetup(convSetup), .convCal(convCal),
    .busy(busy), .strobe(strobe)
  );
endmodule

// File: tb/sim_adc_seq_top.sv
module sim_adc_seq_top;
  localparam int CLK_PERIOD = 10;

  logic clk = 0, rstN = 0;
  logic cfgWrEn = 0, cfgRdEn = 0, cmdValid = 0, cmdMulti = 0, cmdCal = 0;
  logic convDone = 0, convOvr = 0, convOsc = 0, hostRead = 0;
  logic [23:0] cfgWrData = 0, convData = 0;
  logic [23:0] cfgRdData, dataOut;
  logic [3:0]  convSetup, dataSetup;
  logic convStart, convCal, dataReady, busy;
  logic [7:0] chopDiv;
  logic [4:0] accessCnt;
  int checks = 0, fails = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  adc_seq_top u0 (.*);

  task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic tick(); @(negedge clk); endtask

  task automatic writeCfg(input logic [23:0] v);
    cfgWrEn = 1; cfgWrData = v; tick(); cfgWrEn = 0;
  endtask

  task automatic readCfg();
    cfgRdEn = 1; tick(); cfgRdEn = 0;
  endtask

  task automatic readHost();
    hostRead = 1; tick(); hostRead = 0;
  endtask

  task automatic issueCmd(input logic multi, input logic cal);
    cmdValid = 1; cmdMulti = multi; cmdCal = cal; tick();
    cmdValid = 0; cmdMulti = 0; cmdCal = 0;
  endtask

  task automatic doConv(input int expIdx, input logic [23:0] d, input logic expCal,
                        input logic ovr, input logic osc, input string tag);
    int t = 0;
    while (!convStart && t < 50) begin tick(); t++; end
    chk(convStart === 1'b1, {tag, " start seen"}, 32'(convStart), 1);
    chk(convSetup === 4'(expIdx), {tag, " setup"}, 32'(convSetup), 32'(expIdx));
    chk(convCal === expCal, {tag, " cal flag"}, 32'(convCal), 32'(expCal));
    tick();
    convDone = 1; convData = d; convOvr = ovr; convOsc = osc;
    tick();
    convDone = 0; convOvr = 0; convOsc = 0;
    if (!expCal) begin
      chk(dataReady === 1'b1, "R9 ready set", 32'(dataReady), 1);
      chk(dataOut === d, "R9 data", 32'(dataOut), 32'(d));
      chk(dataSetup === 4'(expIdx), "R9 data setup", 32'(dataSetup), 32'(expIdx));
    end
  endtask

  task automatic stopByReset();
    writeCfg(24'h000080);
    writeCfg(24'h000000);
    chk(busy === 1'b0, "R11 idle after reset cycle", 32'(busy), 0);
    chk(cfgRdData[6] === 1'b1, "R11 valid reset flag", 32'(cfgRdData[6]), 1);
    readCfg();
    chk(cfgRdData[6] === 1'b0, "R11 flag cleared by read", 32'(cfgRdData[6]), 0);
  endtask

  function automatic logic [7:0] expChop(input int c);
    case (c)
      0: return 8'd128;
      1: return 8'd8;
      2: return 8'd2;
      default: return 8'd32;
    endcase
  endfunction

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=running expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    int depths[5] = '{0, 1, 2, 3, 15};
    repeat (3) tick();
    rstN = 1;
    tick();
    // R2 reset state
    chk(cfgRdData === 24'h0, "R2 cfg zero", 32'(cfgRdData), 0);
    chk(busy === 1'b0 && convStart === 1'b0, "R2 idle", 32'({busy, convStart}), 0);
    chk(dataReady === 1'b0, "R2 no data", 32'(dataReady), 0);

    // R1 unused bits and status bits not writable
    writeCfg(24'hFFFFFF);
    chk(cfgRdData === 24'h37FF80, "R1 mask", 32'(cfgRdData), 32'h37FF80);
    writeCfg(24'h000000);
    chk(cfgRdData === 24'h000040, "R11 rv after exit", 32'(cfgRdData), 32'h40);
    readCfg();
    chk(cfgRdData === 24'h0, "R11 rv cleared", 32'(cfgRdData), 0);

    // R3 exhaustive chop select
    for (int c = 0; c < 4; c++) begin
      writeCfg(24'(c) << 20);
      chk(chopDiv === expChop(c), "R3 chop ratio", 32'(chopDiv), 32'(expChop(c)));
    end
    // R4 exhaustive depth
    for (int d = 0; d < 16; d++) begin
      writeCfg(24'(d) << 12);
      chk(accessCnt === 5'(d + 1), "R4 access count", 32'(accessCnt), 32'(d + 1));
    end

    // R5 R6 R7 sweep of multi bit, command flag and depth, loop off
    for (int mc = 0; mc < 2; mc++)
      for (int cm = 0; cm < 2; cm++)
        for (int k = 0; k < 5; k++) begin
          int d = depths[k];
          int n = (mc == 1 && cm == 1) ? d + 1 : 1;
          writeCfg((24'(mc) << 18) | (24'(d) << 12));
          issueCmd(1'(cm), 1'b0);
          for (int i = 0; i < n; i++)
            doConv(i, 24'h500000 + 24'(mc * 4096 + cm * 256 + d * 16 + i), 1'b0, 1'b0,
                   1'b0, (n > 1) ? "R6 list" : "R5 single");
          chk(busy === 1'b0 && convStart === 1'b0, "R7 idle after last",
              32'({busy, convStart}), 0);
          readHost();
          chk(dataReady === 1'b0, "R9 ready cleared", 32'(dataReady), 0);
        end

    // R7 looped list without read-convert
    writeCfg((24'h1 << 18) | (24'h1 << 17) | (24'd2 << 12));
    issueCmd(1'b1, 1'b0);
    for (int i = 0; i < 7; i++)
      doConv(i % 3, 24'h600000 + 24'(i), 1'b0, 1'b0, 1'b0, "R7 loop");
    stopByReset();

    // R8 looped list with read-convert
    writeCfg((24'h1 << 18) | (24'h1 << 17) | (24'h1 << 16) | (24'd1 << 12));
    readHost();
    issueCmd(1'b1, 1'b0);
    for (int i = 0; i < 4; i++) begin
      doConv(i % 2, 24'h700000 + 24'(i), 1'b0, 1'b0, 1'b0, "R8 rc");
      for (int w = 0; w < 3; w++) begin
        chk(convStart === 1'b0 && busy === 1'b1, "R8 holds for read",
            32'({convStart, busy}), 1);
        tick();
      end
      readHost();
      chk(dataReady === 1'b0, "R9 ready cleared on read", 32'(dataReady), 0);
      chk(convStart === 1'b1, "R8 start after read", 32'(convStart), 1);
    end
    stopByReset();

    // R8 read-convert ignored with loop off
    writeCfg((24'h1 << 18) | (24'h1 << 16) | (24'd1 << 12));
    issueCmd(1'b1, 1'b0);
    doConv(0, 24'h710000, 1'b0, 1'b0, 1'b0, "R8 no loop");
    chk(convStart === 1'b1, "R8 no wait without loop", 32'(convStart), 1);
    doConv(1, 24'h710001, 1'b0, 1'b0, 1'b0, "R8 no loop");
    chk(busy === 1'b0, "R7 idle after list", 32'(busy), 0);

    // R10 calibration ignores multi and read-convert, keeps loop
    readHost();
    writeCfg((24'h1 << 18) | (24'h1 << 17) | (24'h1 << 16) | (24'd3 << 12));
    issueCmd(1'b1, 1'b1);
    doConv(0, 24'h0, 1'b1, 1'b0, 1'b0, "R10 cal");
    chk(dataReady === 1'b0, "R10 cal no data", 32'(dataReady), 0);
    doConv(0, 24'h0, 1'b1, 1'b0, 1'b0, "R10 cal repeat");
    chk(dataReady === 1'b0, "R10 cal no data", 32'(dataReady), 0);
    stopByReset();

    // R11 commands blocked while reset bit held
    writeCfg(24'h000080);
    issueCmd(1'b0, 1'b0);
    chk(busy === 1'b0 && convStart === 1'b0, "R11 cmd blocked", 32'({busy, convStart}), 0);
    tick();
    chk(busy === 1'b0, "R11 still idle", 32'(busy), 0);
    writeCfg(24'h0);
    readCfg();

    // R12 sticky flags
    issueCmd(1'b0, 1'b0);
    doConv(0, 24'h800000, 1'b0, 1'b1, 1'b0, "R12 ovr");
    chk(cfgRdData[5:4] === 2'b01, "R12 ovr flag", 32'(cfgRdData[5:4]), 1);
    issueCmd(1'b0, 1'b0);
    doConv(0, 24'h800001, 1'b0, 1'b0, 1'b1, "R12 osc");
    chk(cfgRdData[5:4] === 2'b11, "R12 both flags", 32'(cfgRdData[5:4]), 3);
    writeCfg(24'h0);
    chk(cfgRdData[5:4] === 2'b11, "R12 write ignored", 32'(cfgRdData[5:4]), 3);
    writeCfg(24'h000080);
    chk(cfgRdData[5:4] === 2'b00, "R12 cleared by reset cycle", 32'(cfgRdData[5:4]), 0);
    writeCfg(24'h0);
    readCfg();
    writeCfg(24'h000030);
    chk(cfgRdData[5:4] === 2'b00, "R1 status not writable", 32'(cfgRdData[5:4]), 0);

    // R13 stray done while idle
    readHost();
    convDone = 1; convOvr = 1; convOsc = 1; convData = 24'hABCDEF;
    tick();
    convDone = 0; convOvr = 0; convOsc = 0;
    tick();
    chk(dataReady === 1'b0, "R13 stray done no data", 32'(dataReady), 0);
    chk(cfgRdData[5:4] === 2'b00, "R13 stray done no flags", 32'(cfgRdData[5:4]), 0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule